// File: doc/BRIEF.md
# Stereo Pair Mixer with Digital Attenuation

This block takes one left/right pair of 24-bit signed PCM samples and forms two output channels, A and B. A 5-bit routing code picks the source of each output: left, right, the mean of both, or silence. Each routed sample is then scaled by a 7-bit attenuation code in 1 dB steps, can be forced to zero by a pair-wide mute, and can have its sign flipped. A link option lets the A attenuation code drive both outputs.

The configuration inputs come from a register bank outside the block. They are captured on the same clock edge as the sample they apply to. Changes therefore take effect at once on the next sample, with no ramping. Results leave the block two clocks after the input strobe.

Top module: `pair_vol_mixer`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is low and `out_a` and `out_b` are zero until the first result arrives.
- R2: `out_valid` equals `in_valid` delayed by exactly two clocks. The sample and every configuration input are taken on the edge where `in_valid` is high, and outputs hold their value while `out_valid` is low.
- R3: `mix_code[3:2]` selects the source of A and `mix_code[1:0]` selects the source of B. The encoding is 00 for silence, 01 for right, 10 for left and 11 for the mean. The stereo setting is 01001.
- R4: The mean source is floor((left+right)/2), computed at full precision. It always fits in 24 bits.
- R5: When `mix_code[4]` is 1 the code is undecoded, and both outputs are zero.
- R6: For attenuation code n, the output is floor(s*G(n)/32768), where G(n)=round(32768*10^(-n/20)). Code 0 passes the sample unchanged, and codes 20, 40, 60 and 90 give -20, -40, -60 and -90 dB.
- R7: Every code from 97 to 127 has G(n)=0 and yields zero output, the same result as mute.
- R8: When `mute` is high, both outputs are zero whatever the codes, invert bits or samples.
- R9: When `link_ab` is high, both outputs use `vol_a` and `vol_b` has no effect. When it is low, B uses `vol_b`.
- R10: `inv_a` and `inv_b` negate their output after attenuation. The value -8388608 becomes +8388607.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| mix_code | input | 5 | Routing code |
| vol_a | input | 7 | Attenuation code for A, in dB |
| vol_b | input | 7 | Attenuation code for B, in dB |
| mute | input | 1 | Force both outputs to zero |
| link_ab | input | 1 | Use vol_a for both outputs |
| inv_a | input | 1 | Negate output A |
| inv_b | input | 1 | Negate output B |
| out_valid | output | 1 | Result strobe |
| out_a | output | 24 | Output A, signed |
| out_b | output | 24 | Output B, signed |

## Verification
The assertions assume that `in_valid` and the configuration inputs have known values on every clock edge after reset. They also assume a configuration only matters on edges where `in_valid` is high, so the latency, mute and undecoded-code properties compare against inputs taken two edges earlier. The stimulus meets these assumptions by driving every input on the falling edge, with a fully defined value on every cycle. Gaps in `in_valid` are placed between changes of configuration, so the captured settings never depend on edge ordering.

// File: rtl/cvm_pkg.sv
// Package for the pair mixer: shared widths, the routing-source
// encoding, and the constant function that builds the gain table.
// Assumes gain codes below 2^7 and a Q1.15 gain format.
package cvm_pkg;
    localparam int DATA_W    = 24;
    localparam int VOL_W     = 7;
    localparam int MIX_W     = 5;
    localparam int GAIN_FRAC = 15;
    localparam int GAIN_W    = GAIN_FRAC + 1;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_LEFT  = 2'b10,
        SRC_AVG   = 2'b11
    } src_sel_e;

    // 10^(-1/20) in Q2.30.
    localparam longint STEP_Q30 = 64'sd956973408;

    // Gain for attenuation code n in Q1.15, rounded to nearest.
    function automatic logic [GAIN_W-1:0] gain_q15(input int n);
        longint acc;
        acc = 64'sd1 <<< 30;
        for (int k = 0; k < n; k++) begin
            acc = (acc * STEP_Q30 + (64'sd1 <<< 29)) >>> 30;
        end
        acc = (acc + (64'sd1 <<< (29 - GAIN_FRAC))) >>> (30 - GAIN_FRAC);
        return acc[GAIN_W-1:0];
    endfunction
endpackage

// File: rtl/cvm_mix.sv
// Source selector for one output channel.
// Picks left, right, their mean (rounded down) or zero.
// `kill` forces zero for an undecoded routing code.
// Purely combinational; the caller registers the result.
module cvm_mix #(
    parameter int DATA_W = cvm_pkg::DATA_W
) (
    input  logic signed [DATA_W-1:0] left,
    input  logic signed [DATA_W-1:0] right,
    input  cvm_pkg::src_sel_e        sel,
    input  logic                     kill,
    output logic signed [DATA_W-1:0] smp
);
    localparam int SUM_W = DATA_W + 1;

    logic signed [SUM_W-1:0] sum;

    // Full-precision sum; dropping the low bit gives the floored mean.
    always_comb sum = SUM_W'(left) + SUM_W'(right);

    // Route the chosen source, or zero when the code is undecoded.
    always_comb begin
        if (kill) begin
            smp = '0;
        end else begin
            unique case (sel)
                cvm_pkg::SRC_RIGHT: smp = right;
                cvm_pkg::SRC_LEFT:  smp = left;
                cvm_pkg::SRC_AVG:   smp = sum[SUM_W-1:1];
                default:            smp = '0;
            endcase
        end
    end
endmodule

// File: rtl/cvm_gain.sv
// Attenuation, mute and polarity stage for one output channel.
// It looks up a Q1.15 gain for the dB code, multiplies, floors,
// then applies the saturating negate and the mute.
// The result register loads only when `en` is high.
// Assumes `smp` and the controls are stable on edges where `en` is high.
module cvm_gain #(
    parameter int DATA_W    = cvm_pkg::DATA_W,
    parameter int VOL_W     = cvm_pkg::VOL_W,
    parameter int GAIN_FRAC = cvm_pkg::GAIN_FRAC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] smp,
    input  logic [VOL_W-1:0]         vol,
    input  logic                     mute,
    input  logic                     inv,
    output logic signed [DATA_W-1:0] q
);
    localparam int GAIN_W  = GAIN_FRAC + 1;
    localparam int NCODES  = 1 << VOL_W;
    localparam int PROD_W  = DATA_W + GAIN_W + 1;
    localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

    logic [GAIN_W-1:0]         lut [NCODES];
    logic signed [PROD_W-1:0]  prod;
    logic signed [DATA_W-1:0]  att;
    logic signed [DATA_W-1:0]  nxt;

    // Gain table, one constant per attenuation code.
    for (genvar i = 0; i < NCODES; i++) begin : g_lut
        localparam logic [GAIN_W-1:0] GV = cvm_pkg::gain_q15(i);
        assign lut[i] = GV;
    end

    // Scale by the gain; bit selection floors the Q1.15 product.
    always_comb begin
        prod = PROD_W'(smp) * $signed({1'b0, lut[vol]});
        att  = prod[GAIN_FRAC +: DATA_W];
    end

    // Saturating negate, then mute.
    always_comb begin
        if (mute)                     nxt = '0;
        else if (inv && att == MOST_NEG) nxt = MOST_POS;
        else if (inv)                 nxt = -att;
        else                          nxt = att;
    end

    // Output register, loaded only for valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= nxt;
    end

    function automatic logic [DATA_W:0] mag(input logic signed [DATA_W-1:0] v);
        return (v < 0) ? (DATA_W+1)'(-(DATA_W+1)'(v)) : (DATA_W+1)'(v);
    endfunction

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> mag(q) <= mag($past(smp)));  // R10
endmodule

// File: rtl/pair_vol_mixer.sv
// Top of the stereo pair mixer.
// Stage 1 routes the samples and captures all configuration.
// Stage 2 (inside cvm_gain) attenuates, mutes and inverts.
// Latency is two clocks. Configuration is taken only with a valid sample.
module pair_vol_mixer #(
    parameter int DATA_W = cvm_pkg::DATA_W,
    parameter int VOL_W  = cvm_pkg::VOL_W,
    parameter int MIX_W  = cvm_pkg::MIX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic [MIX_W-1:0]  mix_code,
    input  logic [VOL_W-1:0]  vol_a,
    input  logic [VOL_W-1:0]  vol_b,
    input  logic              mute,
    input  logic              link_ab,
    input  logic              inv_a,
    input  logic              inv_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);
    localparam int NCH = 2;

    logic signed [DATA_W-1:0] mixed  [NCH];
    logic [VOL_W-1:0]         vsel   [NCH];
    logic                     isel   [NCH];
    logic signed [DATA_W-1:0] s1_smp [NCH];
    logic [VOL_W-1:0]         s1_vol [NCH];
    logic                     s1_inv [NCH];
    logic signed [DATA_W-1:0] res    [NCH];
    logic                     s1_valid;
    logic                     s1_mute;

    // Per-channel settings: channel 0 is A, channel 1 is B.
    always_comb begin
        vsel[0] = vol_a;
        vsel[1] = link_ab ? vol_a : vol_b;
        isel[0] = inv_a;
        isel[1] = inv_b;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int SEL_LO = 2 * (NCH - 1 - c);

        cvm_mix #(.DATA_W(DATA_W)) u_mix (
            .left  ($signed(in_left)),
            .right ($signed(in_right)),
            .sel   (cvm_pkg::src_sel_e'(mix_code[SEL_LO +: 2])),
            .kill  (mix_code[MIX_W-1]),
            .smp   (mixed[c])
        );

        // Stage 1: capture the routed sample and its controls.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_smp[c] <= '0;
                s1_vol[c] <= '0;
                s1_inv[c] <= 1'b0;
            end else if (in_valid) begin
                s1_smp[c] <= mixed[c];
                s1_vol[c] <= vsel[c];
                s1_inv[c] <= isel[c];
            end
        end

        cvm_gain #(.DATA_W(DATA_W), .VOL_W(VOL_W)) u_gain (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (s1_valid),
            .smp   (s1_smp[c]),
            .vol   (s1_vol[c]),
            .mute  (s1_mute),
            .inv   (s1_inv[c]),
            .q     (res[c])
        );
    end

    // Strobe pipeline and the pair-wide mute capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_mute   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
            if (in_valid) s1_mute <= mute;
        end
    end

    assign out_a = res[0];
    assign out_b = res[1];

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));  // R2
    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && mute, 2) |-> (out_a == '0 && out_b == '0));  // R8
    AST_UNDECODED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && mix_code[MIX_W-1], 2) |-> (out_a == '0 && out_b == '0));  // R5
endmodule

// File: tb/pair_vol_mixer_tb.sv
// Cycle-by-cycle behavioural model of the pair mixer, compared on every clock.
module pair_vol_mixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic [4:0]  mix_code = 5'b01001;
    logic [6:0]  vol_a = '0, vol_b = '0;
    logic        mute = 1'b0, link_ab = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
    logic        out_valid;
    logic [23:0] out_a, out_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    bit live = 0;

    // Two-deep expectation pipe.
    bit     p1_v = 0, p2_v = 0;
    longint p1_a = 0, p1_b = 0, p2_a = 0, p2_b = 0;
    string  p1_t = "", p2_t = "";

    always #2 clk = ~clk;   // 250 MHz

    pair_vol_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right), .mix_code(mix_code),
        .vol_a(vol_a), .vol_b(vol_b), .mute(mute), .link_ab(link_ab),
        .inv_a(inv_a), .inv_b(inv_b),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint src(input int sel, input longint l, input longint r);
        case (sel)
            1: return r;
            2: return l;
            3: return (l + r) >>> 1;
            default: return 0;
        endcase
    endfunction

    function automatic longint gain(input int n);
        real g;
        g = 32768.0 * $pow(10.0, -n / 20.0);
        return longint'($rtoi(g + 0.5));
    endfunction

    function automatic longint chan(input longint s, input int n, input bit m, input bit iv);
        longint r;
        r = (s * gain(n)) >>> 15;
        if (iv) r = -r;
        if (r > 8388607) r = 8388607;
        if (m) r = 0;
        return r;
    endfunction

    // One clock: check the expected result, then drive the next inputs.
    task automatic step(input bit v, input longint l, input longint r, input logic [4:0] mc,
                        input int va, input int vb, input bit m, input bit lk,
                        input bit ia, input bit ib, input string tag);
        longint sa, sb;
        @(negedge clk);
        if (live) begin
            chk({p2_t, " valid"}, longint'(out_valid), longint'(p2_v));
            if (p2_v) begin
                chk({p2_t, " A"}, longint'($signed(out_a)), p2_a);
                chk({p2_t, " B"}, longint'($signed(out_b)), p2_b);
            end
        end
        p2_v = p1_v; p2_a = p1_a; p2_b = p1_b; p2_t = p1_t;
        in_valid = v; in_left = 24'(l); in_right = 24'(r); mix_code = mc;
        vol_a = 7'(va); vol_b = 7'(vb); mute = m; link_ab = lk; inv_a = ia; inv_b = ib;
        sa = mc[4] ? 0 : src(int'(mc[3:2]), l, r);
        sb = mc[4] ? 0 : src(int'(mc[1:0]), l, r);
        p1_v = v; p1_t = tag;
        p1_a = chan(sa, va, m, ia);
        p1_b = chan(sb, lk ? va : vb, m, ib);
    endtask

    task automatic smp(input longint l, input longint r, input logic [4:0] mc,
                       input int va, input int vb, input string tag);
        step(1, l, r, mc, va, vb, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step(0, 0, 0, 5'b01001, 0, 0, 0, 0, 0, 0, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, 5'b01001, 0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        chk("R1 reset valid", longint'(out_valid), 0);
        chk("R1 reset A", longint'(out_a), 0);
        chk("R1 reset B", longint'(out_b), 0);
        live = 1;
        // R3 routing
        smp(1000, -2000, 5'b01001, 0, 0, "R3 stereo");
        smp(-7, 123456, 5'b00110, 0, 0, "R3 swap");
        smp(555, 777, 5'b01010, 0, 0, "R3 left both");
        smp(555, 777, 5'b00000, 0, 0, "R3 silence");
        smp(300, 100, 5'b01111, 0, 0, "R3 mean");
        // R4 mean rounding and extremes
        smp(-3, 0, 5'b01111, 0, 0, "R4 odd negative");
        smp(8388607, 8388607, 5'b01111, 0, 0, "R4 max");
        smp(-8388608, -8388608, 5'b01111, 0, 0, "R4 min");
        smp(-8388608, 8388607, 5'b01101, 0, 0, "R4 mixed");
        // R5 undecoded
        smp(4000, 5000, 5'b11001, 0, 0, "R5 undecoded");
        smp(4000, 5000, 5'b10000, 0, 0, "R5 undecoded");
        // R6 attenuation points
        smp(8388607, -8388608, 5'b01001, 20, 40, "R6 -20/-40");
        smp(8388607, -8388608, 5'b01001, 60, 90, "R6 -60/-90");
        smp(-1, 1, 5'b01001, 1, 6, "R6 small");
        // R7 gain-zero codes
        smp(8388607, 8388607, 5'b01001, 96, 97, "R7 edge");
        smp(-8388608, 8388607, 5'b01001, 127, 110, "R7 deep");
        // R8 mute
        step(1, 8388607, -8388608, 5'b01111, 0, 0, 1, 0, 1, 1, "R8 mute");
        step(1, 1234, 4321, 5'b01001, 0, 0, 1, 1, 0, 0, "R8 mute");
        // R9 link
        step(1, 100000, 100000, 5'b01001, 20, 0, 0, 1, 0, 0, "R9 linked");
        step(1, 100000, 100000, 5'b01001, 20, 0, 0, 0, 0, 0, "R9 unlinked");
        step(1, 100000, 100000, 5'b01001, 0, 127, 0, 1, 0, 0, "R9 b ignored");
        // R10 invert
        step(1, -8388608, 8388607, 5'b01001, 0, 0, 0, 0, 1, 1, "R10 extremes");
        step(1, 5000, -5000, 5'b01001, 10, 10, 0, 0, 1, 0, "R10 one side");
        // R2 gaps in the strobe
        step(0, 99, 99, 5'b00000, 0, 0, 1, 0, 0, 0, "R2 gap");
        smp(42, 43, 5'b01001, 0, 0, "R2 after gap");
        step(0, 0, 0, 5'b01001, 0, 0, 0, 0, 0, 0, "R2 gap");
        step(0, 0, 0, 5'b01001, 0, 0, 0, 0, 0, 0, "R2 gap");
        // Mixed pseudo-random traffic
        begin
            int unsigned s = 32'h1234_5678;
            for (int i = 0; i < 400; i++) begin
                int unsigned a, b, c;
                s = s * 1664525 + 1013904223; a = s;
                s = s * 1664525 + 1013904223; b = s;
                s = s * 1664525 + 1013904223; c = s;
                step(c[0] | c[1], longint'($signed(a[23:0])), longint'($signed(b[23:0])),
                     c[8:4], int'(c[15:9]), int'(c[22:16]), c[23] & c[24],
                     c[25], c[26], c[27], "R6 random");
            end
        end
        for (int i = 0; i < 3; i++) step(0, 0, 0, 5'b01001, 0, 0, 0, 0, 0, 0, "R2 drain");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule